// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block brings a single-rank SDR or low-power (mobile) SDRAM out of power-up and keeps it refreshed afterwards. After reset it holds the clock enable high and sends only NOP commands for a stabilization wait. It then precharges every bank, issues eight auto-refresh commands and loads the mode register with the configured CAS latency and burst length. For low-power parts it also loads the extended mode register with the self-refresh temperature, partial-array and drive-strength fields. Every command is followed by a parameterized number of NOP cycles.

Once the sequence is finished the block raises a ready flag and enters normal mode. A down-counter, loaded from a period input (the refresh interval times the clock frequency, e.g. 1562 for 15.625 µs at 100 MHz), requests an auto-refresh each time it expires. An external user port asks for the command bus with a request line and receives a grant. A refresh that comes due while the grant is held waits until the grant is released. A current-mode code is exposed for observation.

Top module: `sdr_init_refresh`

## Requirements
- R1: While reset is low, cke_o is 0, ready_o and grant_o are 0 and the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (NOP). After reset is released, cke_o is 1 and only NOPs are sent for PWRUP_CYC cycles, with mode_o = 1.
- R2: The first command after the wait is precharge-all: pins 4'b0010 with addr_o[10] = 1, mode_o = 2, in the cycle PWRUP_CYC cycles after reset release.
- R3: Exactly eight auto-refresh commands (pins 4'b0001, mode_o = 4) follow. The first comes T_RP+1 cycles after the precharge, and each later one comes T_RFC+1 cycles after the previous one.
- R4: Mode register load (pins 4'b0000, mode_o = 3) follows T_RFC+1 cycles after the eighth refresh. It has ba_o = 0 and addr_o[6:0] = {cas_lat_i, 1'b0, burst_len_i}.
- R5: When mobile_i is 1, an extended mode load (pins 4'b0000, mode_o = 5) comes T_MRD+1 cycles after the mode load. It has ba_o = 2'b10 and addr_o[6:0] = {drv_str_i, tcsr_i, pasr_i}.
- R6: When mobile_i is 0, no extended mode load is sent and normal mode begins T_MRD+1 cycles after the mode load.
- R7: ready_o stays 0 until normal mode is first entered, T_MRD+1 cycles after the last load command. From then on it stays 1, and mode_o reads 0 while idle.
- R8: In normal mode, the first auto-refresh is issued ref_period_i cycles after ready_o rises. Later ones follow every ref_period_i cycles.
- R9: In normal mode, a held user_req_i is granted. While grant_o is 1, only NOPs appear on the command pins.
- R10: A refresh that comes due while grant_o is 1 is held pending. It is issued in the cycle grant_o falls after user_req_i drops, and the next refresh follows ref_period_i cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mobile_i | input | 1 | Low-power part: send the extended mode load |
| cas_lat_i | input | 3 | CAS latency field |
| burst_len_i | input | 3 | Burst length field |
| pasr_i | input | 3 | Partial-array self-refresh field |
| tcsr_i | input | 2 | Temperature-compensated self-refresh field |
| drv_str_i | input | 2 | Drive strength field |
| ref_period_i | input | REF_W | Refresh period in clock cycles |
| user_req_i | input | 1 | User port request for the command bus |
| grant_o | output | 1 | User port owns the command bus |
| ready_o | output | 1 | Initialization complete |
| mode_o | output | 3 | Current mode code (0 normal, 1 wait, 2 precharge, 3 load, 4 refresh, 5 extended load) |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address bus |

## Verification
The power-up sequence is walked against a table of expected commands, gaps and mode codes. It is run twice: once with the mobile input high and once with it low. This tells the extended-load path apart from the skip path and exposes off-by-one spacing in any wait. Distinct non-symmetric field values for latency, burst length and the extended fields show mis-ordered or mis-placed address bits. In normal mode, free-running refresh spacing is compared with refresh held behind a long grant. This separates a counter that reloads on issue from one that reloads on expiry, and a pending flag that is kept from one that is lost.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;
  typedef enum logic [2:0] {
    ST_PWR, ST_PRE, ST_CBR, ST_MRS, ST_EMRS, ST_RUN, ST_RWAIT
  } seq_st_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS, CMD_EMRS
  } cmd_e;

  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_WAIT   = 3'd1;
  localparam logic [2:0] MODE_PRE    = 3'd2;
  localparam logic [2:0] MODE_LMR    = 3'd3;
  localparam logic [2:0] MODE_REF    = 3'd4;
  localparam logic [2:0] MODE_XLMR   = 3'd5;
endpackage

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int REF_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic [REF_W-1:0] period_i,
  output logic             due_o
);
  logic [REF_W-1:0] tmr_q;

  // issue cycle counts as one period cycle, hence period-1 on reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tmr_q <= '0;
    else if (!run_i)           tmr_q <= period_i;
    else if (reload_i)         tmr_q <= period_i - REF_W'(1);
    else if (tmr_q != '0)      tmr_q <= tmr_q - REF_W'(1);
  end

  assign due_o = run_i && (tmr_q == '0);

  a_r10_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (due_o && !reload_i) |=> due_o);
endmodule

// File: rtl/sdr_cmd_drv.sv
module sdr_cmd_drv
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  cmd_e              cmd_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic [2:0]        pasr_i,
  input  logic [1:0]        tcsr_i,
  input  logic [1:0]        drv_str_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [3:0] pins;

  always_comb begin
    pins   = 4'b0111;
    ba_o   = 2'b00;
    addr_o = '0;
    unique case (cmd_i)
      CMD_PRE: begin
        pins       = 4'b0010;
        addr_o[10] = 1'b1;
      end
      CMD_REF:  pins = 4'b0001;
      CMD_MRS: begin
        pins        = 4'b0000;
        addr_o[6:0] = {cas_lat_i, 1'b0, burst_len_i};
      end
      CMD_EMRS: begin
        pins        = 4'b0000;
        ba_o        = 2'b10;
        addr_o[6:0] = {drv_str_i, tcsr_i, pasr_i};
      end
      default: ;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;
endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
  import sdr_init_pkg::*;
#(
  parameter int PWRUP_CYC  = 20,
  parameter int T_RP       = 2,
  parameter int T_RFC      = 4,
  parameter int T_MRD      = 2,
  parameter int N_INIT_REF = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mobile_i,
  input  logic       user_req_i,
  input  logic       due_i,
  output cmd_e       cmd_o,
  output logic [2:0] mode_o,
  output logic       run_o,
  output logic       reload_o,
  output logic       grant_o,
  output logic       ready_o
);
  localparam int T_A   = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int T_B   = (T_A > T_MRD) ? T_A : T_MRD;
  localparam int T_MAX = (T_B > PWRUP_CYC) ? T_B : PWRUP_CYC;
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int IDX_W = (N_INIT_REF > 1) ? $clog2(N_INIT_REF) : 1;

  seq_st_e          st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             issue_q, issue_n;
  logic             grant_q, grant_n;
  logic             fire_ref;

  assign fire_ref = (st_q == ST_RUN) && due_i && !grant_q;

  always_comb begin
    st_n    = st_q;
    cnt_n   = cnt_q;
    idx_n   = idx_q;
    issue_n = 1'b0;
    if (st_q == ST_RUN) begin
      if (fire_ref) begin
        st_n  = ST_RWAIT;
        cnt_n = CNT_W'(T_RFC);
      end
    end else if (issue_q) begin
      issue_n = 1'b0;
    end else if (cnt_q == CNT_W'(1)) begin
      unique case (st_q)
        ST_PWR: begin
          st_n = ST_PRE; cnt_n = CNT_W'(T_RP); issue_n = 1'b1;
        end
        ST_PRE: begin
          st_n = ST_CBR; cnt_n = CNT_W'(T_RFC); issue_n = 1'b1; idx_n = '0;
        end
        ST_CBR: begin
          issue_n = 1'b1;
          if (idx_q == IDX_W'(N_INIT_REF - 1)) begin
            st_n = ST_MRS; cnt_n = CNT_W'(T_MRD);
          end else begin
            cnt_n = CNT_W'(T_RFC); idx_n = idx_q + IDX_W'(1);
          end
        end
        ST_MRS: begin
          if (mobile_i) begin
            st_n = ST_EMRS; cnt_n = CNT_W'(T_MRD); issue_n = 1'b1;
          end else begin
            st_n = ST_RUN;
          end
        end
        default: st_n = ST_RUN;
      endcase
    end else begin
      cnt_n = cnt_q - CNT_W'(1);
    end
  end

  assign grant_n = (st_q == ST_RUN) && !fire_ref && user_req_i && (grant_q || !due_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_PWR;
      cnt_q   <= CNT_W'(PWRUP_CYC);
      idx_q   <= '0;
      issue_q <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      idx_q   <= idx_n;
      issue_q <= issue_n;
      grant_q <= grant_n;
    end
  end

  always_comb begin
    cmd_o = CMD_NOP;
    if (issue_q) begin
      unique case (st_q)
        ST_PRE:  cmd_o = CMD_PRE;
        ST_CBR:  cmd_o = CMD_REF;
        ST_MRS:  cmd_o = CMD_MRS;
        ST_EMRS: cmd_o = CMD_EMRS;
        default: cmd_o = CMD_NOP;
      endcase
    end else if (fire_ref) begin
      cmd_o = CMD_REF;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PWR:   mode_o = MODE_WAIT;
      ST_PRE:   mode_o = MODE_PRE;
      ST_CBR:   mode_o = MODE_REF;
      ST_MRS:   mode_o = MODE_LMR;
      ST_EMRS:  mode_o = MODE_XLMR;
      ST_RUN:   mode_o = fire_ref ? MODE_REF : MODE_NORMAL;
      default:  mode_o = MODE_REF;
    endcase
  end

  assign run_o    = (st_q == ST_RUN) || (st_q == ST_RWAIT);
  assign ready_o  = run_o;
  assign reload_o = fire_ref;
  assign grant_o  = grant_q;

  a_r7_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r6_emrs_only_mobile: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EMRS) |-> mobile_i);
  a_r9_no_ref_when_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_q |-> (cmd_o == CMD_NOP));
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
  import sdr_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int REF_W      = 12,
  parameter int PWRUP_CYC  = 20,
  parameter int T_RP       = 2,
  parameter int T_RFC      = 4,
  parameter int T_MRD      = 2,
  parameter int N_INIT_REF = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mobile_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        burst_len_i,
  input  logic [2:0]        pasr_i,
  input  logic [1:0]        tcsr_i,
  input  logic [1:0]        drv_str_i,
  input  logic [REF_W-1:0]  ref_period_i,
  input  logic              user_req_i,
  output logic              grant_o,
  output logic              ready_o,
  output logic [2:0]        mode_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  cmd_e cmd;
  logic run, reload, due, cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= 1'b1;
  end
  assign cke_o = cke_q;

  sdr_seq_fsm #(
    .PWRUP_CYC(PWRUP_CYC), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .N_INIT_REF(N_INIT_REF)
  ) u_fsm (
    .clk_i, .rst_ni, .mobile_i, .user_req_i,
    .due_i(due), .cmd_o(cmd), .mode_o, .run_o(run),
    .reload_o(reload), .grant_o, .ready_o
  );

  sdr_ref_timer #(.REF_W(REF_W)) u_tmr (
    .clk_i, .rst_ni, .run_i(run), .reload_i(reload),
    .period_i(ref_period_i), .due_o(due)
  );

  sdr_cmd_drv #(.ADDR_W(ADDR_W)) u_drv (
    .cmd_i(cmd), .cas_lat_i, .burst_len_i, .pasr_i, .tcsr_i, .drv_str_i,
    .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .ba_o, .addr_o
  );

  a_r9_nop_while_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));
  a_r1_no_grant_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !grant_o);
  a_r4_load_bank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_LMR && !cs_n_o) |-> (ba_o == 2'b00));
endmodule

// File: tb/tb_sdr_init_refresh.sv
module tb_sdr_init_refresh;
  localparam int PWR = 10, TRP = 2, TRFC = 3, TMRD = 2, PER = 40, AW = 13;

  logic clk = 0, rst_ni = 0;
  logic mobile = 1, user_req = 0;
  logic grant, ready, cke, cs_n, ras_n, cas_n, we_n;
  logic [2:0] mode;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sdr_init_refresh #(.ADDR_W(AW), .REF_W(12), .PWRUP_CYC(PWR), .T_RP(TRP),
    .T_RFC(TRFC), .T_MRD(TMRD), .N_INIT_REF(8)) dut (
    .clk_i(clk), .rst_ni, .mobile_i(mobile), .cas_lat_i(3'b010),
    .burst_len_i(3'b011), .pasr_i(3'b001), .tcsr_i(2'b10), .drv_str_i(2'b01),
    .ref_period_i(12'(PER)), .user_req_i(user_req), .grant_o(grant),
    .ready_o(ready), .mode_o(mode), .cke_o(cke), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr));

  // init command table: gap from previous observation, pins, mode
  // entry 0 gap is PWR-1 because one cycle is consumed by the R1 check
  localparam int V_GAP  [0:10] = '{PWR-1, TRP+1, TRFC+1, TRFC+1, TRFC+1, TRFC+1,
                                   TRFC+1, TRFC+1, TRFC+1, TRFC+1, TMRD+1};
  localparam int V_PINS [0:10] = '{2, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0};
  localparam int V_MODE [0:10] = '{2, 4, 4, 4, 4, 4, 4, 4, 4, 3, 5};

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cmd(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (pins() == 4'b0111 && gap < 2000);
  endtask

  task automatic reset_and_check();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    chk(cke == 0 && ready == 0 && grant == 0 && pins() == 4'b0111, "R1 reset state",
        {cke, ready, grant, pins()}, 7'b0000111);
    rst_ni = 1;
    @(negedge clk);
    chk(cke == 1 && mode == 1 && pins() == 4'b0111, "R1 power-up wait", {cke, mode, pins()}, 8'b10010111);
  endtask

  task automatic walk_init(input int n);
    int gap;
    string tag;
    for (int i = 0; i < n; i++) begin
      wait_cmd(gap);
      tag = (i == 0) ? "R2" : (i < 9) ? "R3" : (i == 9) ? "R4" : "R5";
      chk(gap == V_GAP[i], $sformatf("%s gap entry %0d", tag, i), gap, V_GAP[i]);
      chk(pins() == 4'(V_PINS[i]), $sformatf("%s pins entry %0d", tag, i), pins(), V_PINS[i]);
      chk(mode == 3'(V_MODE[i]), $sformatf("%s mode entry %0d", tag, i), mode, V_MODE[i]);
      if (i == 0) chk(addr[10] == 1, "R2 precharge all bit", addr[10], 1);
      if (i == 9) chk(addr == 13'h23 && ba == 0, "R4 mode load fields", {ba, addr}, 13'h23);
      if (i == 10) chk(addr == 13'h31 && ba == 2'b10, "R5 ext load fields", {ba, addr}, {2'b10, 13'h31});
    end
  endtask

  initial begin
    int gap;
    bit bad;
    reset_and_check();
    walk_init(11);
    repeat (TMRD) @(negedge clk);
    chk(ready == 0, "R7 ready low before normal", ready, 0);
    @(negedge clk);
    chk(ready == 1 && mode == 0, "R7 ready in normal mode", {ready, mode}, 4'b1000);

    wait_cmd(gap);
    chk(gap == PER && pins() == 4'b0001 && mode == 4, "R8 first refresh", gap, PER);
    wait_cmd(gap);
    chk(gap == PER && pins() == 4'b0001, "R8 refresh period", gap, PER);

    user_req = 1;
    repeat (TRFC + 3) @(negedge clk);
    chk(grant == 1, "R9 grant given", grant, 1);
    bad = 0;
    for (int k = 0; k < PER + 5; k++) begin
      @(negedge clk);
      if (pins() != 4'b0111 || grant != 1) bad = 1;
    end
    chk(!bad, "R9 only NOP while granted", bad, 0);
    chk(ready == 1, "R7 ready held", ready, 1);
    user_req = 0;
    @(negedge clk);
    chk(grant == 0 && pins() == 4'b0001, "R10 pending refresh on release", {grant, pins()}, 5'b00001);
    wait_cmd(gap);
    chk(gap == PER, "R10 reload on issue", gap, PER);

    mobile = 0;
    reset_and_check();
    walk_init(10);
    bad = 0;
    for (int k = 0; k < TMRD; k++) begin
      @(negedge clk);
      if (pins() != 4'b0111 || ready != 0) bad = 1;
    end
    chk(!bad, "R6 no extended load", bad, 0);
    @(negedge clk);
    chk(ready == 1 && mode == 0, "R6 normal after mode load", {ready, mode}, 4'b1000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule